// File: doc/BRIEF.md
# Serial Host Transmit Holding Register

This block carries words from a processor to a host over a serial link. The processor writes a 24-bit word into a holding register. A data-empty flag, and an interrupt that can be enabled, tell the processor when the register can accept the next word. When the serial shifter is idle and the holding register has a word, the word moves into the shifter in a single cycle. The empty flag sets on that same cycle, so the processor can write the next word while the current one is still going out.

A mode input sets the word length of each transfer: 8, 16 or 24 bits. A shorter word is always taken from the most significant bytes of the holding register. The shifter sends MSB first and advances one bit for each pulse of an external bit-clock strobe. After the chosen number of bits it goes idle. A single synchronous clear input covers every kind of reset and the low-power stop condition. It empties the register and stops the shifter.

Top module: `shtx_top`

## Requirements
- R1: After reset, and on the cycle after `clr` is high, `tx_empty`=1, `busy`=0, `sdo`=0 and `ovr_err`=0. This holds even if a word was being shifted.
- R2: A write (`wr_en`=1) makes `tx_empty` read 0 on the following cycle.
- R3: `tx_irq` is 1 exactly when `irq_en` is 1 and `tx_empty` is 1.
- R4: With `mode`=0 at load time, the shifter sends bits 23:16 of the word, MSB first, one bit per strobe. After 8 strobes it is idle.
- R5: With `mode`=1 at load time, bits 23:8 are sent MSB first. After 16 strobes the shifter is idle.
- R6: With `mode`=2 or `mode`=3 at load time, all 24 bits are sent MSB first. After 24 strobes the shifter is idle.
- R7: Suppose the shifter is idle and the holding register is full. On the next cycle the word is in the shifter, `busy`=1, `sdo` shows the first bit and `tx_empty`=1.
- R8: A write while `tx_empty`=0 and the shifter is busy replaces the held word. It also sets `ovr_err`, which stays set until `clr`. The replacing word is the one transmitted.
- R9: `mode` is sampled only when a word is loaded into the shifter. Changing it during a transfer does not change the bits sent or the bit count.
- R10: A write in the same cycle a held word is loaded into the shifter does not set `ovr_err`. Both words are then sent in order.
- R11: Strobes while the shifter is idle have no effect: `busy` stays 0 and `sdo` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear (stop or any reset type) |
| wr_en | input | 1 | Processor write strobe for the holding register |
| wr_data | input | 24 | Word to transmit |
| irq_en | input | 1 | Transmit interrupt enable |
| mode | input | 2 | Word length: 0=8, 1=16, 2 or 3=24 bits |
| bit_stb | input | 1 | Bit-clock strobe, advances the shifter by one bit |
| sdo | output | 1 | Serial data out, MSB first, 0 when idle |
| busy | output | 1 | Shifter holds bits still to be sent |
| tx_empty | output | 1 | Holding register can accept a word |
| tx_irq | output | 1 | Transmit interrupt request |
| ovr_err | output | 1 | Sticky flag: a full holding register was overwritten |

## Verification
The hardest case to reach from the ports is a write that falls in exactly the cycle where a held word passes into an idle shifter. In that cycle the register is both drained and refilled, and no overrun should be flagged. The bench reaches it by issuing two writes on back-to-back cycles while the shifter is idle. It then checks that both words come out in order with the error flag still clear. The random phase changes `mode` between strobes in the middle of each transfer and varies the gaps between strobes, which exercises the load-time sampling of the word length.

// File: rtl/shtx_pkg.sv
package shtx_pkg;
   // Word length selector as seen on the mode input.
   typedef enum logic [1:0] {
      SHTX_W8   = 2'd0,
      SHTX_W16  = 2'd1,
      SHTX_W24  = 2'd2,
      SHTX_W24X = 2'd3
   } shtx_mode_e;

   localparam int unsigned SHTX_MODE_W = 2;
endpackage

// File: rtl/shtx_hold.sv
module shtx_hold #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              load_i,
   output logic [WORD_W-1:0] hold_q,
   output logic              full_q,
   output logic              ovr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (clr) begin
         hold_q <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (wr_en) begin
            hold_q <= wr_data;
            full_q <= 1'b1;
            if (full_q && !load_i) ovr_q <= 1'b1;
         end else if (load_i) begin
            full_q <= 1'b0;
         end
      end
   end

   // R8: overwrite of a word that is not being drained flags an error
   a_r8_overwrite_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && full_q && !load_i && !clr |=> ovr_q);
   // R8: error flag is sticky until clear
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q && !clr |=> ovr_q);
   // R10: drain and refill in one cycle is not an overrun
   a_r10_no_false_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      !ovr_q && wr_en && load_i && !clr |=> !ovr_q && full_q);
endmodule

// File: rtl/shtx_align.sv
module shtx_align #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 5
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [1:0]        mode_i,
   output logic [WORD_W-1:0] word_o,
   output logic [CNT_W-1:0]  nbits_o
);
   localparam int unsigned NBYTES = WORD_W / BYTE_W;
   localparam int unsigned NB1 = (NBYTES < 1) ? NBYTES : 1;
   localparam int unsigned NB2 = (NBYTES < 2) ? NBYTES : 2;
   localparam int unsigned NB3 = (NBYTES < 3) ? NBYTES : 3;
   localparam logic [CNT_W-1:0] BITS_M0 = CNT_W'(NB1 * BYTE_W);
   localparam logic [CNT_W-1:0] BITS_M1 = CNT_W'(NB2 * BYTE_W);
   localparam logic [CNT_W-1:0] BITS_M2 = CNT_W'(NB3 * BYTE_W);
   localparam logic [CNT_W-1:0] BITS_M3 = CNT_W'(NBYTES * BYTE_W);

   always_comb begin
      unique case (mode_i)
         shtx_pkg::SHTX_W8:  nbits_o = BITS_M0;
         shtx_pkg::SHTX_W16: nbits_o = BITS_M1;
         shtx_pkg::SHTX_W24: nbits_o = BITS_M2;
         default:            nbits_o = BITS_M3;
      endcase
   end

   // Byte lanes counted from the MSB end; lanes beyond the word length read zero.
   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      localparam int unsigned HI = WORD_W - 1 - b * BYTE_W;
      localparam logic [CNT_W-1:0] START = CNT_W'(b * BYTE_W);
      assign word_o[HI -: BYTE_W] = (nbits_o > START) ? word_i[HI -: BYTE_W] : '0;
   end
endmodule

// File: rtl/shtx_shifter.sv
module shtx_shifter #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load_i,
   input  logic [WORD_W-1:0] load_word,
   input  logic [CNT_W-1:0]  load_nbits,
   input  logic              bit_stb,
   output logic              sdo,
   output logic              busy
);
   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         cnt  <= '0;
      end else if (clr) begin
         sreg <= '0;
         cnt  <= '0;
      end else if (load_i) begin
         sreg <= load_word;
         cnt  <= load_nbits;
      end else if (bit_stb && cnt != '0) begin
         sreg <= {sreg[WORD_W-2:0], 1'b0};
         cnt  <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);
   assign sdo  = busy & sreg[WORD_W-1];

   // R11: an idle shifter stays idle under strobes
   a_r11_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !load_i && !clr |=> !busy && !sdo);
   // R4: each strobe consumes exactly one bit
   a_r4_one_bit_per_stb: assert property (@(posedge clk) disable iff (!rst_n)
      busy && bit_stb && !load_i && !clr |=> cnt == $past(cnt) - 1'b1);
   // R9: without a strobe the shifter state does not move
   a_r9_hold_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !bit_stb && !load_i && !clr |=> $stable(cnt) && $stable(sreg));
   // R6: the count never exceeds the word width
   always_comb a_r6_cnt_bound: assert (!rst_n || cnt <= CNT_W'(WORD_W));
endmodule

// File: rtl/shtx_top.sv
module shtx_top #(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              irq_en,
   input  logic [1:0]        mode,
   input  logic              bit_stb,
   output logic              sdo,
   output logic              busy,
   output logic              tx_empty,
   output logic              tx_irq,
   output logic              ovr_err
);
   localparam int unsigned CNT_W = $clog2(WORD_W + 1);

   if (BYTE_W == 0 || WORD_W % BYTE_W != 0) begin : g_bad_byte
      $error("shtx_top: WORD_W must be a nonzero multiple of BYTE_W");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("shtx_top: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] hold_q, aligned;
   logic [CNT_W-1:0]  nbits;
   logic              full_q, load;

   assign load = full_q & ~busy;

   shtx_hold #(.WORD_W(WORD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
      .load_i(load), .hold_q(hold_q), .full_q(full_q), .ovr_q(ovr_err));

   shtx_align #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_align (
      .word_i(hold_q), .mode_i(mode), .word_o(aligned), .nbits_o(nbits));

   shtx_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load_i(load), .load_word(aligned),
      .load_nbits(nbits), .bit_stb(bit_stb), .sdo(sdo), .busy(busy));

   assign tx_empty = ~full_q;
   assign tx_irq   = irq_en & tx_empty;

   // R1: clear empties the register and stops the shifter
   a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> tx_empty && !busy && !ovr_err && !sdo);
   // R2: a write makes the register full
   a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !clr |=> !tx_empty);
   // R7: idle shifter takes a held word in one cycle
   a_r7_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_empty && !busy && !wr_en && !clr |=> tx_empty && busy);
endmodule

// File: tb/shtx_top_tb.sv
module shtx_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        wr_en = 1'b0;
   logic [23:0] wr_data = '0;
   logic        irq_en = 1'b0;
   logic [1:0]  mode = '0;
   logic        bit_stb = 1'b0;
   logic        sdo, busy, tx_empty, tx_irq, ovr_err;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   shtx_top u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
      .irq_en(irq_en), .mode(mode), .bit_stb(bit_stb), .sdo(sdo), .busy(busy),
      .tx_empty(tx_empty), .tx_irq(tx_irq), .ovr_err(ovr_err));

   function automatic int nbits_of(input logic [1:0] m);
      return (m == 2'd0) ? 8 : (m == 2'd1) ? 16 : 24;
   endfunction

   function automatic logic [23:0] expect_word(input logic [23:0] d, input logic [1:0] m);
      return (m == 2'd0) ? (d & 24'hFF0000) : (m == 2'd1) ? (d & 24'hFFFF00) : d;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   task automatic write_word(input logic [23:0] d, input logic [1:0] m);
      wr_en = 1'b1; wr_data = d; mode = m;
      tick;
      wr_en = 1'b0;
   endtask

   // Collects n bits, one per strobe, left aligned; may scramble mode between strobes.
   task automatic shift_out(input int n, input bit scramble, output logic [23:0] got);
      got = '0;
      for (int i = 0; i < n; i++) begin
         got[23-i] = sdo;
         if (scramble) mode = 2'($urandom);
         bit_stb = 1'b1;
         tick;
         bit_stb = 1'b0;
         repeat ($urandom % 3) tick;
      end
   endtask

   task automatic send_check(input logic [23:0] d, input logic [1:0] m,
                             input string req, input bit scramble);
      logic [23:0] got;
      write_word(d, m);
      chk("R2 empty cleared by write", 32'(tx_empty), 32'd0);
      tick;
      chk("R7 loaded: busy", 32'(busy), 32'd1);
      chk("R7 loaded: empty set", 32'(tx_empty), 32'd1);
      chk("R3 irq follows empty", 32'(tx_irq), 32'(irq_en));
      shift_out(nbits_of(m), scramble, got);
      chk(req, 32'(got), 32'(expect_word(d, m)));
      chk({req, " idle after word"}, 32'({busy, sdo}), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [23:0] got;
      logic [23:0] a, b, c;
      void'($urandom(32'h5EED_0724));
      repeat (3) tick;
      rst_n = 1'b1;
      tick;
      // R1: reset state
      chk("R1 reset state", 32'({tx_empty, busy, sdo, ovr_err, tx_irq}), 32'b10000);
      irq_en = 1'b1;
      tick;
      chk("R3 irq with enable and empty", 32'(tx_irq), 32'd1);

      // R11: strobes while idle
      repeat (3) begin bit_stb = 1'b1; tick; end
      bit_stb = 1'b0;
      chk("R11 idle strobes ignored", 32'({busy, sdo, tx_empty}), 32'b001);

      send_check(24'hA5C3_0F, 2'd0, "R4 8-bit word", 1'b0);
      send_check(24'h3C_96E1, 2'd1, "R5 16-bit word", 1'b0);
      send_check(24'hD2_4B87, 2'd2, "R6 24-bit word", 1'b0);
      send_check(24'h81_7E55, 2'd3, "R6 mode 3 is 24-bit", 1'b0);
      send_check(24'hC3_FFFF, 2'd0, "R9 mode changes mid-word", 1'b1);

      // R8: overwrite while shifter busy
      a = 24'h123456; b = 24'hABCDEF; c = 24'h9A_BC71;
      write_word(a, 2'd2);
      tick;
      write_word(b, 2'd2);
      chk("R8 first queued write no error", 32'(ovr_err), 32'd0);
      write_word(c, 2'd1);
      chk("R8 overwrite sets error", 32'(ovr_err), 32'd1);
      shift_out(24, 1'b0, got);
      chk("R8 current word unaffected", 32'(got), 32'(a));
      mode = 2'd1;
      tick;
      chk("R8 replacement loaded", 32'(busy), 32'd1);
      shift_out(16, 1'b0, got);
      chk("R8 replacement word sent", 32'(got), 32'(expect_word(c, 2'd1)));
      chk("R8 error sticky", 32'(ovr_err), 32'd1);
      clr = 1'b1; tick; clr = 1'b0;
      chk("R1 clear state", 32'({tx_empty, busy, sdo, ovr_err}), 32'b1000);

      // R10: write in the load cycle
      a = 24'hF0_1234; b = 24'h5A_0000;
      write_word(a, 2'd0);
      write_word(b, 2'd0);
      chk("R10 no overrun on load-cycle write", 32'({ovr_err, tx_empty, busy}), 32'b001);
      shift_out(8, 1'b0, got);
      chk("R10 first word", 32'(got), 32'(expect_word(a, 2'd0)));
      tick;
      shift_out(8, 1'b0, got);
      chk("R10 second word", 32'(got), 32'(expect_word(b, 2'd0)));
      chk("R10 error still clear", 32'(ovr_err), 32'd0);

      // R1: clear in the middle of a transfer
      write_word(24'hFFFFFF, 2'd2);
      tick;
      shift_out(3, 1'b0, got);
      clr = 1'b1; tick; clr = 1'b0;
      chk("R1 clear mid-shift", 32'({tx_empty, busy, sdo}), 32'b100);

      // Random words, modes, interrupt enable and mid-word mode changes
      for (int k = 0; k < 40; k++) begin
         logic [1:0] m;
         logic [23:0] d;
         m = 2'($urandom);
         d = 24'($urandom);
         irq_en = 1'($urandom);
         send_check(d, m, (m == 2'd0) ? "R4 random" : (m == 2'd1) ? "R5 random" : "R6 random", 1'b1);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule